// File: doc/BRIEF.md
# Tone Transceiver Host Register Interface

This block is the processor-facing side of a tone-signalling transceiver. A 4-bit host bus with one address line, an active-low chip select and separate active-low read and write strobes reaches five registers. There is a write-only transmit code register, a read-only receive code register, a read-only status register whose event flags clear when it is read, and two control registers that share one address. A pointer bit steers control writes between the two control registers.

The block also contains the burst sequencer. After a transmit write in burst mode it gates the tone generator on for a fixed number of millisecond ticks, then off for the same number, and then reports that the transmitter is ready. The count doubles in call-progress mode. A tone validator feeds the block a new-data pulse with its 4-bit code and a delayed-steering level. A comparator feeds it the call-progress square wave. The active-low interrupt pin shows one of three things, chosen by the control bits: pending events, the call-progress wave, or the delayed-steering level.

Top module: `dtmf_host_regs`

## Requirements
- R1: Register decode. A write at address 0 loads the transmit code, which appears on `tx_code`. A read at address 0 returns the last received code. A write at address 1 goes to a control register. A read at address 1 returns the status word {bit3 delayed steering, bit2 receive full, bit1 transmit ready, bit0 event = bit1 OR bit2}.
- R2: `dout_en` is high only while `cs_n` and `rd_n` are both low.
- R3: Control A bits are: 0 tone enable, 1 call-progress mode, 2 interrupt enable, 3 select-B. A control write with bit 3 set sends exactly the next control write to control B, and later control writes go to A again. Control B bits are: 0 burst disable (drives no tone-sequencer burst when high), 1 test, 2 single tone (`single_tone`), 3 column select (`column_sel`).
- R4: A `rx_new` pulse latches `rx_code` into the receive register and sets receive-full, which also sets bit 0.
- R5: The read that finds status flags set still returns them. The flags clear once the status read strobe ends. A new event in the same cycle as the clear keeps its flag set.
- R6: In burst mode, a transmit write holds `tone_on` high (given tone enable) for 51 ticks of `ms_tick` and low for 51 more, and then sets transmit-ready. In call-progress mode both phases are 102 ticks.
- R7: A transmit write during a running burst restarts the tone phase at full length.
- R8: With burst disabled, `tone_on` follows the tone-enable bit directly, and transmit-ready is cleared and stays clear.
- R9: In DTMF mode with interrupt enable set, `irq_n` is low while bit 0 of status is set. With interrupt enable and test both clear, `irq_n` stays high.
- R10: In call-progress mode with interrupt enable set, `irq_n` follows `cp_square`.
- R11: In DTMF mode with test set, `irq_n` follows `dly_steer`.
- R12: Status bit 3 reflects the current `dly_steer` level.
- R13: After reset, both control registers and all flags are zero. `irq_n` is high, and `tone_on`, `single_tone` and `column_sel` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 1 | Register address |
| din | input | 4 | Host write data |
| dout | output | 4 | Host read data |
| dout_en | output | 1 | Read data bus drive enable |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rx_new | input | 1 | Validator new-code pulse |
| rx_code | input | 4 | Validated received code |
| dly_steer | input | 1 | Delayed-steering level |
| cp_square | input | 1 | Call-progress comparator output |
| irq_n | output | 1 | Interrupt / multiplexed output, active low |
| tx_code | output | 4 | Code for the tone generator |
| tone_on | output | 1 | Tone generator enable |
| single_tone | output | 1 | Single-tone select to generator |
| column_sel | output | 1 | Column (high) or row tone select |

## Verification
The assertions check, on every cycle, the following behaviours. The select-B pointer is consumed by exactly one control write. A status clear lasts one cycle and empties receive-full unless a new code arrives in that cycle. Transmit-ready is never set while burst mode is disabled. A running sequencer always holds a nonzero count, and a transmit write puts it back in the tone phase. `irq_n` goes low only when interrupt enable or test is set. Only the bench scenarios can show the rest: the exact 51 and 102 tick phase lengths, the restart length, that the read which clears the flags still returns them, and the routing of the control writes through their effect on the tone outputs and on `irq_n`.

// File: rtl/dhr_pkg.sv
package dhr_pkg;
    parameter int unsigned REG_W = 4;
    typedef logic [REG_W-1:0] reg_t;

    // control A bit positions
    localparam int unsigned A_TONE   = 0;
    localparam int unsigned A_CPMODE = 1;
    localparam int unsigned A_IRQEN  = 2;
    localparam int unsigned A_SELB   = 3;
    // control B bit positions
    localparam int unsigned B_NOBURST = 0;
    localparam int unsigned B_TEST    = 1;
    localparam int unsigned B_SINGLE  = 2;
    localparam int unsigned B_COLUMN  = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_TONE  = 2'd1,
        SEQ_PAUSE = 2'd2
    } seq_e;
endpackage

// File: rtl/dhr_strobe.sv
module dhr_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic addr,
    output logic tx_wr_o,
    output logic ctrl_wr_o,
    output logic stat_clr_o
);
    typedef struct packed {
        logic wr_act;
        logic stat_rd;
    } st_t;

    st_t  st_q, st_d;
    logic wr_act, stat_act, wr_edge;

    always_comb begin
        wr_act       = !cs_n && !wr_n;
        stat_act     = !cs_n && !rd_n && addr;
        wr_edge      = wr_act && !st_q.wr_act;
        st_d.wr_act  = wr_act;
        st_d.stat_rd = stat_act;
        tx_wr_o      = wr_edge && !addr;
        ctrl_wr_o    = wr_edge && addr;
        stat_clr_o   = st_q.stat_rd && !stat_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr_o |=> !stat_clr_o);
endmodule

// File: rtl/dhr_ctrl.sv
module dhr_ctrl
    import dhr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr_i,
    input  reg_t wdata_i,
    output reg_t cra_o,
    output reg_t crb_o
);
    typedef struct packed {
        logic sel_b;
        reg_t cra;
        reg_t crb;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr_i) begin
            if (st_q.sel_b) begin
                st_d.crb   = wdata_i;
                st_d.sel_b = 1'b0;
            end else begin
                st_d.cra   = wdata_i;
                st_d.sel_b = wdata_i[A_SELB];
            end
        end
        cra_o = st_q.cra;
        crb_o = st_q.crb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    sel_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && st_q.sel_b) |=> !st_q.sel_b);
endmodule

// File: rtl/dhr_burst_seq.sv
module dhr_burst_seq
    import dhr_pkg::*;
#(
    parameter int unsigned BURST_TICKS = 51,
    parameter int unsigned CP_MULT     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic burst_en_i,
    input  logic cp_mode_i,
    input  logic tick_i,
    output logic tone_gate_o,
    output logic done_o
);
    localparam int unsigned LONG_TICKS = BURST_TICKS * CP_MULT;
    localparam int unsigned CNT_W      = $clog2(LONG_TICKS + 1);

    typedef struct packed {
        seq_e             state;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t              st_q, st_d;
    logic [CNT_W-1:0] len_w;
    logic             last;

    always_comb begin
        st_d   = st_q;
        len_w  = cp_mode_i ? CNT_W'(LONG_TICKS) : CNT_W'(BURST_TICKS);
        last   = tick_i && (st_q.cnt == CNT_W'(1));
        done_o = 1'b0;
        if (!burst_en_i) begin
            st_d.state = SEQ_IDLE;
            st_d.cnt   = '0;
        end else if (start_i) begin
            st_d.state = SEQ_TONE;
            st_d.len   = len_w;
            st_d.cnt   = len_w;
        end else begin
            case (st_q.state)
                SEQ_TONE: begin
                    if (last) begin
                        st_d.state = SEQ_PAUSE;
                        st_d.cnt   = st_q.len;
                    end else if (tick_i) begin
                        st_d.cnt = st_q.cnt - CNT_W'(1);
                    end
                end
                SEQ_PAUSE: begin
                    if (last) begin
                        st_d.state = SEQ_IDLE;
                        st_d.cnt   = '0;
                        done_o     = 1'b1;
                    end else if (tick_i) begin
                        st_d.cnt = st_q.cnt - CNT_W'(1);
                    end
                end
                default: st_d.cnt = '0;
            endcase
        end
        tone_gate_o = (st_q.state == SEQ_TONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: SEQ_IDLE, len: '0, cnt: '0};
        else        st_q <= st_d;
    end

    // R6
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state != SEQ_IDLE) |-> (st_q.cnt != '0));
    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && burst_en_i) |=> (st_q.state == SEQ_TONE));
endmodule

// File: rtl/dhr_status.sv
module dhr_status
    import dhr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_new_i,
    input  reg_t rx_code_i,
    input  logic done_i,
    input  logic burst_en_i,
    input  logic clr_i,
    output reg_t rx_data_o,
    output logic rx_full_o,
    output logic tx_empty_o
);
    typedef struct packed {
        reg_t rx_data;
        logic rx_full;
        logic tx_empty;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.rx_full  = 1'b0;
            st_d.tx_empty = 1'b0;
        end
        if (!burst_en_i) st_d.tx_empty = 1'b0;
        if (rx_new_i) begin
            st_d.rx_full = 1'b1;
            st_d.rx_data = rx_code_i;
        end
        if (done_i && burst_en_i) st_d.tx_empty = 1'b1;
        rx_data_o  = st_q.rx_data;
        rx_full_o  = st_q.rx_full;
        tx_empty_o = st_q.tx_empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_new_i |=> st_q.rx_full);
    // R5
    rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !rx_new_i) |=> !st_q.rx_full);
    // R8
    noburst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_en_i |=> !st_q.tx_empty);
endmodule

// File: rtl/dtmf_host_regs.sv
module dtmf_host_regs
    import dhr_pkg::*;
#(
    parameter int unsigned BURST_TICKS = 51,
    parameter int unsigned CP_MULT     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       addr,
    input  logic [3:0] din,
    output logic [3:0] dout,
    output logic       dout_en,
    input  logic       ms_tick,
    input  logic       rx_new,
    input  logic [3:0] rx_code,
    input  logic       dly_steer,
    input  logic       cp_square,
    output logic       irq_n,
    output logic [3:0] tx_code,
    output logic       tone_on,
    output logic       single_tone,
    output logic       column_sel
);
    typedef struct packed {
        reg_t tx_code;
    } st_t;

    st_t  st_q, st_d;
    logic tx_wr, ctrl_wr, stat_clr;
    reg_t cra, crb, rx_data, status_word;
    logic rx_full, tx_empty, tone_gate, seq_done, burst_en, cp_mode, event_flag;

    dhr_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .tx_wr_o(tx_wr), .ctrl_wr_o(ctrl_wr), .stat_clr_o(stat_clr)
    );

    dhr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr), .wdata_i(din),
        .cra_o(cra), .crb_o(crb)
    );

    dhr_burst_seq #(.BURST_TICKS(BURST_TICKS), .CP_MULT(CP_MULT)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(tx_wr), .burst_en_i(burst_en),
        .cp_mode_i(cp_mode), .tick_i(ms_tick), .tone_gate_o(tone_gate),
        .done_o(seq_done)
    );

    dhr_status u_status (
        .clk(clk), .rst_n(rst_n), .rx_new_i(rx_new), .rx_code_i(rx_code),
        .done_i(seq_done), .burst_en_i(burst_en), .clr_i(stat_clr),
        .rx_data_o(rx_data), .rx_full_o(rx_full), .tx_empty_o(tx_empty)
    );

    always_comb begin
        st_d = st_q;
        if (tx_wr) st_d.tx_code = din;

        burst_en    = !crb[B_NOBURST];
        cp_mode     = cra[A_CPMODE];
        event_flag  = rx_full || tx_empty;
        status_word = {dly_steer, rx_full, tx_empty, event_flag};

        dout_en = !cs_n && !rd_n;
        dout    = addr ? status_word : rx_data;

        if (cp_mode && cra[A_IRQEN])
            irq_n = cp_square;
        else if (!cp_mode && crb[B_TEST])
            irq_n = dly_steer;
        else if (!cp_mode && cra[A_IRQEN] && event_flag)
            irq_n = 1'b0;
        else
            irq_n = 1'b1;

        tx_code     = st_q.tx_code;
        tone_on     = cra[A_TONE] && (crb[B_NOBURST] || tone_gate);
        single_tone = crb[B_SINGLE];
        column_sel  = crb[B_COLUMN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (cra[A_IRQEN] || crb[B_TEST]));
endmodule

// File: tb/dtmf_host_regs_tb.sv
module dtmf_host_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
    logic [3:0] din = '0;
    logic [3:0] dout;
    logic       dout_en;
    logic       ms_tick = 1'b0, rx_new = 1'b0;
    logic [3:0] rx_code = '0;
    logic       dly_steer = 1'b0, cp_square = 1'b0;
    logic       irq_n;
    logic [3:0] tx_code;
    logic       tone_on, single_tone, column_sel;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dtmf_host_regs u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .ms_tick(ms_tick), .rx_new(rx_new), .rx_code(rx_code),
        .dly_steer(dly_steer), .cp_square(cp_square), .irq_n(irq_n),
        .tx_code(tx_code), .tone_on(tone_on), .single_tone(single_tone),
        .column_sel(column_sel)
    );

    function automatic logic [3:0] exp_status(logic dly, logic rxf, logic txr);
        return {dly, rxf, txr, rxf | txr};
    endfunction

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(logic a, logic [3:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic host_rd(logic a, output logic [3:0] d, output logic en);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1;
        d = dout; en = dout_en;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    task automatic push_rx(logic [3:0] c);
        @(negedge clk); rx_new = 1'b1; rx_code = c;
        @(negedge clk); rx_new = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0] d;
        logic       en;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        chk("R13 irq_n", {3'b0, irq_n}, 4'h1);
        chk("R13 tone/single/col", {1'b0, tone_on, single_tone, column_sel}, 4'h0);
        // R2 idle bus
        chk("R2 idle en", {3'b0, dout_en}, 4'h0);
        cs_n = 1'b1; rd_n = 1'b0; #1;
        chk("R2 cs high en", {3'b0, dout_en}, 4'h0);
        rd_n = 1'b1;
        host_rd(1'b1, d, en);
        chk("R13 status", d, 4'h0);
        chk("R2 read en", {3'b0, en}, 4'h1);

        // R1 transmit write
        host_wr(1'b0, 4'h7);
        chk("R1 tx_code", tx_code, 4'h7);

        // R3 control routing
        host_wr(1'b1, 4'b1000);
        host_wr(1'b1, 4'b1100);
        chk("R3 crb via pointer", {2'b0, single_tone, column_sel}, 4'b0011);
        host_wr(1'b1, 4'b0000);
        host_wr(1'b1, 4'b0000);
        chk("R3 back to A", {2'b0, single_tone, column_sel}, 4'b0011);

        // R8 non-burst tone follows enable
        host_wr(1'b1, 4'b1000);
        host_wr(1'b1, 4'b0001);
        chk("R3 crb rewrite", {2'b0, single_tone, column_sel}, 4'b0000);
        host_wr(1'b1, 4'b0001);
        chk("R8 tone on", {3'b0, tone_on}, 4'h1);
        host_wr(1'b1, 4'b0000);
        chk("R8 tone off", {3'b0, tone_on}, 4'h0);

        // R4 receive and R5 clear-on-read
        push_rx(4'h5);
        host_rd(1'b1, d, en);
        chk("R4 status full", d, exp_status(0, 1, 0));
        host_rd(1'b0, d, en);
        chk("R1 rx data", d, 4'h5);
        host_rd(1'b1, d, en);
        chk("R5 cleared", d, 4'h0);

        // R5 event coincident with clear
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1; rx_new = 1'b1; rx_code = 4'h9;
        @(negedge clk);
        rx_new = 1'b0;
        host_rd(1'b1, d, en);
        chk("R5 set wins", d, exp_status(0, 1, 0));
        host_rd(1'b1, d, en);

        // R12 delayed steering level
        dly_steer = 1'b1;
        host_rd(1'b1, d, en);
        chk("R12 dly high", d, exp_status(1, 0, 0));
        dly_steer = 1'b0;
        host_rd(1'b1, d, en);
        chk("R12 dly low", d, 4'h0);

        // R9 interrupt
        host_wr(1'b1, 4'b0100);
        chk("R9 idle irq", {3'b0, irq_n}, 4'h1);
        push_rx(4'h3);
        chk("R9 irq low", {3'b0, irq_n}, 4'h0);
        host_rd(1'b1, d, en);
        @(negedge clk);
        chk("R9 irq released", {3'b0, irq_n}, 4'h1);
        host_wr(1'b1, 4'b0000);
        push_rx(4'h4);
        chk("R9 disabled irq", {3'b0, irq_n}, 4'h1);
        host_rd(1'b1, d, en);

        // R10 call-progress passthrough
        host_wr(1'b1, 4'b0110);
        cp_square = 1'b1; #1;
        chk("R10 cp high", {3'b0, irq_n}, 4'h1);
        cp_square = 1'b0; #1;
        chk("R10 cp low", {3'b0, irq_n}, 4'h0);

        // R11 test mode
        host_wr(1'b1, 4'b1000);
        host_wr(1'b1, 4'b0011);
        dly_steer = 1'b1; #1;
        chk("R11 test high", {3'b0, irq_n}, 4'h1);
        dly_steer = 1'b0; #1;
        chk("R11 test low", {3'b0, irq_n}, 4'h0);
        host_wr(1'b1, 4'b1000);
        host_wr(1'b1, 4'b0000);

        // R6 DTMF burst
        host_wr(1'b1, 4'b0101);
        host_wr(1'b0, 4'h3);
        chk("R6 burst start", {3'b0, tone_on}, 4'h1);
        ticks(50);
        chk("R6 tone 50", {3'b0, tone_on}, 4'h1);
        ticks(1);
        chk("R6 tone end", {3'b0, tone_on}, 4'h0);
        ticks(50);
        chk("R6 pause 50 irq", {3'b0, irq_n}, 4'h1);
        ticks(1);
        chk("R6 ready irq", {3'b0, irq_n}, 4'h0);
        host_rd(1'b1, d, en);
        chk("R6 ready status", d, exp_status(0, 0, 1));

        // R6 call-progress burst
        host_wr(1'b1, 4'b0011);
        host_wr(1'b0, 4'h8);
        ticks(101);
        chk("R6 cp tone 101", {3'b0, tone_on}, 4'h1);
        ticks(1);
        chk("R6 cp tone end", {3'b0, tone_on}, 4'h0);
        ticks(101);
        host_rd(1'b1, d, en);
        chk("R6 cp pause 101", d, 4'h0);
        ticks(1);
        host_rd(1'b1, d, en);
        chk("R6 cp ready", d, exp_status(0, 0, 1));

        // R7 restart
        host_wr(1'b1, 4'b0001);
        host_wr(1'b0, 4'h2);
        ticks(30);
        host_wr(1'b0, 4'h4);
        ticks(50);
        chk("R7 restarted tone", {3'b0, tone_on}, 4'h1);
        chk("R7 tx_code", tx_code, 4'h4);
        ticks(1);
        chk("R7 tone end", {3'b0, tone_on}, 4'h0);
        ticks(51);
        // R8 leaving burst mode clears ready
        host_wr(1'b1, 4'b1000);
        host_wr(1'b1, 4'b0001);
        host_rd(1'b1, d, en);
        chk("R8 ready cleared", d, 4'h0);

        // random receive / transmit traffic
        for (int i = 0; i < 30; i++) begin
            logic [3:0] c, t;
            logic       ds;
            c  = 4'($urandom);
            t  = 4'($urandom);
            ds = 1'($urandom);
            dly_steer = ds;
            push_rx(c);
            host_rd(1'b0, d, en);
            chk("R1 rand rx", d, c);
            host_rd(1'b1, d, en);
            chk("R4 rand status", d, exp_status(ds, 1, 0));
            host_rd(1'b1, d, en);
            chk("R5 rand clear", d, exp_status(ds, 0, 0));
            host_wr(1'b0, t);
            chk("R1 rand tx", tx_code, t);
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule